// File: doc/BRIEF.md
# Three-Port Parallel Register Interface

This block gives a host three 8-bit data registers (ports A, B and C) and a write-only control location, all reached through a 2-bit address, a chip select and a write enable that act within a single clock cycle. A write to a port stores the data. A read returns the stored value one cycle later through a registered read bus. External logic sees each port's current value and gets a one-cycle strobe per port for every read and write, so it can supply or consume data at that moment.

The control location serves two purposes, chosen by the top data bit. With that bit set, the lower seven bits become the configuration word. With it clear, the write is a single-bit command on port C: a 3-bit index picks a bit, and the lowest data bit sets or clears it while the other port C bits stay as they were. Every port update, including the single-bit command, first saves the port's old value into a per-port previous-value register. Logic outside the block can then compare the old and new values.

Top module: `pario_regif`

## Requirements
- R1: Address 0 selects port A, 1 selects port B and 2 selects port C. A write (cs=1, we=1) stores wdata in the addressed port, and the new value is visible on port_val from the next cycle on. Port i occupies port_val bits [8*i+7:8*i].
- R2: A read of address 3 (cs=1, we=0) puts 0xFF on rdata in the next cycle.
- R3: A write to address 3 with wdata bit 7 = 1 loads wdata[6:0] into cfg_word and leaves all three ports unchanged.
- R4: A write to address 3 with wdata bit 7 = 0 changes only port C bit wdata[3:1]. That bit takes the value of wdata[0]. The other seven port C bits, ports A and B, and cfg_word all stay unchanged.
- R5: Every port write and every single-bit command copies the port's value from just before the update into that port's prev_val field (same bit layout as port_val). A port that is not updated keeps its prev_val.
- R6: A port read pulses rd_strobe[i] for exactly one cycle, in the cycle after the access, where bit 0 is port A, bit 1 is port B and bit 2 is port C. A port write, and a single-bit command for port C, pulses wr_strobe[i] in the same way. A configuration load and a read of address 3 pulse no strobe.
- R7: After reset, every port, every prev_val field, cfg_word, rdata and both strobe vectors are zero.
- R8: While cs=0, no port, prev_val, cfg_word or rdata changes, and no strobe is raised.
- R9: A read of port i (cs=1, we=0, address i) puts that port's current value on rdata in the next cycle. rdata keeps its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| port_val | output | 24 | Current values of ports C, B, A (A in the low byte) |
| prev_val | output | 24 | Values before each port's last update, same layout |
| cfg_word | output | 7 | Stored configuration word |
| rd_strobe | output | 3 | Per-port read pulse |
| wr_strobe | output | 3 | Per-port write pulse |

## Verification
Each access is applied on a falling edge and takes effect on the next rising edge. The port values, the previous values, the configuration word, the read data and the strobes then all show the result one cycle after the access. The bench therefore checks every output at the following falling edge, against a model that it steps once per access, before it drives the next access. Because each strobe lasts only one cycle, that same sample also checks that the strobe from the access before has gone low. A directed sweep covers every port C bit index, setting and clearing each one. A seeded random run then mixes reads, writes, idle cycles and both kinds of control write.

// File: rtl/pario_pkg.sv
package pario_pkg;
   localparam int unsigned PORT_CNT = 3;

   typedef enum logic [1:0] {
      SEL_PA   = 2'd0,
      SEL_PB   = 2'd1,
      SEL_PC   = 2'd2,
      SEL_CTRL = 2'd3
   } sel_e;

   typedef struct packed {
      logic [PORT_CNT-1:0] port_wr;
      logic [PORT_CNT-1:0] port_rd;
      logic                cfg_ld;
      logic                bit_op;
      logic                ctrl_rd;
   } dec_t;
endpackage

// File: rtl/pario_decode.sv
module pario_decode
   import pario_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              cs,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output dec_t              dec
);
   localparam int unsigned MODE_BIT = DATA_W - 1;

   always_comb begin
      dec = '0;
      if (cs) begin
         if (sel_e'(addr) == SEL_CTRL) begin
            dec.cfg_ld  = we & wdata[MODE_BIT];
            dec.bit_op  = we & ~wdata[MODE_BIT];
            dec.ctrl_rd = ~we;
         end else begin
            dec.port_wr[addr] = we;
            dec.port_rd[addr] = ~we;
         end
      end
   end

   always_comb begin
      assert ($countones({dec.port_wr, dec.port_rd, dec.cfg_ld, dec.bit_op, dec.ctrl_rd}) <= 1)
         else $error("AST_ONE_ACTION"); // R6
   end
endmodule

// File: rtl/pario_bitop.sv
module pario_bitop #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] cur,
   input  logic [DATA_W-1:0] cmd,
   output logic [DATA_W-1:0] nxt
);
   localparam int unsigned IDX_W = $clog2(DATA_W);

   generate
      if (IDX_W + 2 > DATA_W) begin : g_bad_width
         $error("pario_bitop: DATA_W too small for index field");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic [DATA_W-1:0] onehot;

   assign idx    = cmd[IDX_W:1];
   assign onehot = {{(DATA_W-1){1'b0}}, 1'b1} << idx;

   always_comb begin
      if (cmd[0]) nxt = cur | onehot;
      else        nxt = cur & ~onehot;
   end

   always_comb begin
      assert ($countones(nxt ^ cur) <= 1) else $error("AST_BITOP_ONE_BIT"); // R4
   end
endmodule

// File: rtl/pario_port.sv
module pario_port #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] val_q,
   output logic [DATA_W-1:0] prev_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q  <= '0;
         prev_q <= '0;
      end else if (load) begin
         prev_q <= val_q;
         val_q  <= din;
      end
   end

   AST_PREV_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> prev_q == $past(val_q)); // R5
   AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(val_q) && $stable(prev_q)); // R8
endmodule

// File: rtl/pario_regif.sv
module pario_regif
   import pario_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs,
   input  logic                       we,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   output logic [PORT_CNT*DATA_W-1:0] port_val,
   output logic [PORT_CNT*DATA_W-1:0] prev_val,
   output logic [DATA_W-2:0]          cfg_word,
   output logic [PORT_CNT-1:0]        rd_strobe,
   output logic [PORT_CNT-1:0]        wr_strobe
);
   localparam int unsigned CFG_W  = DATA_W - 1;
   localparam int unsigned C_IDX  = int'(SEL_PC);

   generate
      if (ADDR_W != 2) begin : g_bad_addr
         $error("pario_regif: ADDR_W must be 2");
      end
   endgenerate

   dec_t              dec;
   logic [DATA_W-1:0] pc_bitop;

   pario_decode #(.DATA_W(DATA_W)) u_dec (
      .cs(cs), .we(we), .addr(addr), .wdata(wdata), .dec(dec)
   );

   pario_bitop #(.DATA_W(DATA_W)) u_bitop (
      .cur(port_val[C_IDX*DATA_W +: DATA_W]), .cmd(wdata), .nxt(pc_bitop)
   );

   generate
      for (genvar i = 0; i < PORT_CNT; i++) begin : g_port
         logic              ld;
         logic [DATA_W-1:0] din;
         if (i == C_IDX) begin : g_bitable
            assign ld  = dec.port_wr[i] | dec.bit_op;
            assign din = dec.bit_op ? pc_bitop : wdata;
         end else begin : g_plain
            assign ld  = dec.port_wr[i];
            assign din = wdata;
         end
         pario_port #(.DATA_W(DATA_W)) u_port (
            .clk(clk), .rst_n(rst_n), .load(ld), .din(din),
            .val_q(port_val[i*DATA_W +: DATA_W]),
            .prev_q(prev_val[i*DATA_W +: DATA_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_word  <= '0;
         rdata     <= '0;
         rd_strobe <= '0;
         wr_strobe <= '0;
      end else begin
         if (dec.cfg_ld) cfg_word <= wdata[CFG_W-1:0];
         if (dec.ctrl_rd)
            rdata <= '1;
         else if (|dec.port_rd)
            rdata <= port_val[addr*DATA_W +: DATA_W];
         rd_strobe <= dec.port_rd;
         wr_strobe <= dec.port_wr | (PORT_CNT'(dec.bit_op) << C_IDX);
      end
   end

   AST_CTRL_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && !we && addr == ADDR_W'(3)) |=> rdata == '1); // R2
   AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && we && addr == ADDR_W'(3) && wdata[DATA_W-1]) |=>
         (cfg_word == $past(wdata[CFG_W-1:0])) && $stable(port_val)); // R3
   AST_BITOP_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && we && addr == ADDR_W'(3) && !wdata[DATA_W-1]) |=>
         $countones(port_val ^ $past(port_val)) <= 1 && $stable(cfg_word)); // R4
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_strobe, wr_strobe})); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> rd_strobe == '0 && wr_strobe == '0 && $stable(rdata) && $stable(cfg_word)); // R8
endmodule

// File: tb/pario_regif_test.sv
module pario_regif_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0, we = 1'b0;
   logic [1:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [23:0] port_val, prev_val;
   logic [6:0]  cfg_word;
   logic [2:0]  rd_strobe, wr_strobe;

   int n_tests = 0, n_fail = 0;
   logic [7:0] m_val [3];
   logic [7:0] m_prev [3];
   logic [6:0] m_cfg;
   logic [7:0] m_rdata;
   logic [2:0] m_rd, m_wr;

   pario_regif uut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
      .rdata(rdata), .port_val(port_val), .prev_val(prev_val), .cfg_word(cfg_word),
      .rd_strobe(rd_strobe), .wr_strobe(wr_strobe)
   );

   always #4 clk = ~clk;

   initial begin
      #1600000;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] bit_cmd(input logic [7:0] cur, input logic [7:0] cmd);
      logic [7:0] m = 8'h01 << cmd[3:1];
      return cmd[0] ? (cur | m) : (cur & ~m);
   endfunction

   task automatic check_all(input string tag);
      chk({tag, " R1 port_val"}, {8'h0, port_val}, {8'h0, m_val[2], m_val[1], m_val[0]});
      chk({tag, " R5 prev_val"}, {8'h0, prev_val}, {8'h0, m_prev[2], m_prev[1], m_prev[0]});
      chk({tag, " R3 cfg_word"}, {25'h0, cfg_word}, {25'h0, m_cfg});
      chk({tag, " R9 rdata"}, {24'h0, rdata}, {24'h0, m_rdata});
      chk({tag, " R6 strobes"}, {26'h0, rd_strobe, wr_strobe}, {26'h0, m_rd, m_wr});
   endtask

   // Drive one access on a falling edge, step the model, check at the next falling edge.
   task automatic access(input logic c, input logic w, input logic [1:0] a, input logic [7:0] d,
                         input string tag);
      cs = c; we = w; addr = a; wdata = d;
      m_rd = '0; m_wr = '0;
      if (c) begin
         if (a == 2'd3) begin
            if (!w) m_rdata = 8'hFF;                       // R2
            else if (d[7]) m_cfg = d[6:0];                 // R3
            else begin                                     // R4
               m_prev[2] = m_val[2];
               m_val[2]  = bit_cmd(m_val[2], d);
               m_wr[2]   = 1'b1;
            end
         end else if (w) begin
            m_prev[a] = m_val[a];
            m_val[a]  = d;
            m_wr[a]   = 1'b1;
         end else begin
            m_rdata = m_val[a];
            m_rd[a] = 1'b1;
         end
      end
      @(negedge clk);
      check_all(tag);
      cs = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 3; i++) begin m_val[i] = '0; m_prev[i] = '0; end
      m_cfg = '0; m_rdata = '0; m_rd = '0; m_wr = '0;
      repeat (3) @(negedge clk);
      check_all("R7 reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R9: write and read back each port
      access(1, 1, 2'd0, 8'hA5, "R1 wrA");
      access(1, 1, 2'd1, 8'h3C, "R1 wrB");
      access(1, 1, 2'd2, 8'hF0, "R1 wrC");
      access(1, 0, 2'd1, 8'h00, "R9 rdB");
      access(0, 0, 2'd0, 8'h00, "R9 idle hold");
      access(1, 0, 2'd3, 8'h00, "R2 ctrl read");
      access(1, 1, 2'd3, 8'h80 | 8'h55, "R3 cfg load");
      access(1, 1, 2'd0, 8'h5A, "R5 second wrA");

      // R4: every bit index, set then clear, from both all-zero and all-one backgrounds
      access(1, 1, 2'd2, 8'h00, "R4 clrC");
      for (int b = 0; b < 8; b++) begin
         access(1, 1, 2'd3, {4'h0, 3'(b), 1'b1}, "R4 set");
         chk("R4 one bit set", {24'h0, port_val[23:16] ^ prev_val[23:16]}, {24'h0, 8'h01 << b});
         access(1, 1, 2'd3, {4'h0, 3'(b), 1'b0}, "R4 clear");
      end
      access(1, 1, 2'd2, 8'hFF, "R4 fillC");
      for (int b = 0; b < 8; b++) begin
         access(1, 1, 2'd3, {4'h0, 3'(b), 1'b0}, "R4 clear");
         chk("R4 one bit cleared", {24'h0, port_val[23:16]}, {24'h0, ~(8'h01 << b)});
         access(1, 1, 2'd3, {4'h0, 3'(b), 1'b1}, "R4 set");
      end
      // R8: cs low with write data present changes nothing
      access(0, 1, 2'd0, 8'h11, "R8 deselected write");

      // Random mix
      for (int n = 0; n < 3000; n++) begin
         logic c = ($urandom % 5) != 0;
         access(c, 1'($urandom), 2'($urandom), 8'($urandom), "rand");
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule